// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that lets an external bus controller read and write a small bank of 8-bit control registers inside the chip. SCL and SDA arrive as raw pad inputs. Each passes through a two-flop synchroniser, and the block drives SDA only by pulling it low through an output-enable (`sdaOe` high means the pad drives 0). START and STOP are recognised as SDA edges while the synchronised SCL is high. The block answers to one hard-wired 7-bit device address.

A write is the address with the direction bit clear, then a register pointer, then one data byte. Each of these bytes is acknowledged. The data byte lands in the bank on the SCL rising edge of its acknowledge clock. A read is a combined transfer. A pointer write is followed by a repeated START and the address with the direction bit set. The block then returns one byte and lets go of SDA for the controller's acknowledge bit. The pointer survives STOP and repeated START, so a read may also reuse the pointer left by an earlier transfer. On-chip logic reaches the same bank through a parallel port with a combinational read and a clocked write.

Top module: `i2c_reg_target`

## Requirements
- R1: While reset is active and after its release, every bank register reads 0x00 and `sdaOe` is low.
- R2: The first byte after a START or repeated START is taken MSB first. Its bits 7..1 are compared with the device address 7'b0011010 and its bit 0 is the direction (0 = write, 1 = read). On a match the block pulls SDA low for the whole ninth clock.
- R3: In a write, the pointer byte and the data byte that follow the address are each acknowledged on their ninth clock. Both bytes are taken MSB first.
- R4: The data byte is stored in the register selected by the pointer three clock cycles after SCL rises at the pin for the data byte's acknowledge clock. This is the synchronised SCL rising edge, and the store happens neither earlier nor at STOP.
- R5: After address+read, the block returns the addressed register MSB first and changes SDA only while the synchronised SCL is low.
- R6: After the eighth read bit, SDA is released for the controller's acknowledge bit. The block then drives nothing until the next START or STOP.
- R7: An address byte that does not match gets no acknowledge. All later bytes up to the next START or STOP are ignored: no acknowledge and no register change.
- R8: A repeated START at any point returns the block to address reception. A write that completes after the repeated START uses the pointer sent after it.
- R9: A pointer at or above the bank size (8 by default) is still acknowledged. A write to it changes no register, and a read from it returns 0x00.
- R10: A second data byte in the same write is not acknowledged and is not stored.
- R11: The register pointer is kept across STOP. A read with no pointer write in the same transfer returns the register at the last pointer loaded.
- R12: The parallel port reads `bank[hostAddr]` combinationally. It writes `hostWdata` at the clock edge where `hostWe` is high, and the I2C side reads that value back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw SCL from the pad |
| sdaIn | input | 1 | Raw SDA from the pad |
| sdaOe | output | 1 | High pulls SDA low |
| hostAddr | input | AW (3) | Parallel-port register index |
| hostWe | input | 1 | Parallel-port write strobe |
| hostWdata | input | 8 | Parallel-port write data |
| hostRdata | output | 8 | Parallel-port read data |

## Verification
The bench compares the bank on every clock, so a store one cycle early, one cycle late, or deferred to STOP shows up as a miscompare. Transfers to a wrong address must draw no acknowledge and leave the bank untouched. A design that kept listening would acknowledge the later bytes or overwrite a register. Out-of-range pointers, a repeated START in the middle of a write, a trailing second data byte and a read that reuses a pointer kept across STOP each target a separate wrong path: a wrapped index, a stale pointer, an auto-increment store, or a pointer cleared by STOP.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  // strobes issued by the control towards the datapath
  typedef struct packed {
    logic shiftIn;   // take the synchronised SDA bit into the receive shifter
    logic loadPtr;   // latch the received byte as register pointer
    logic commitWr;  // store the received byte into the bank
    logic loadTx;    // load the transmit shifter from the bank
    logic shiftTx;   // advance the transmit shifter by one bit
  } tgtStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_WAIT,
    ST_ACK_DRIVE,
    ST_ACK_HOLD,
    ST_TX
  } tgtState_t;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_PTR,
    BY_DATA,
    BY_EXTRA
  } byteKind_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '1;
        else       chain[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '1;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0011010,
  parameter int         BYTE_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic [6:0] rxLow7,
  input  logic       txBit,
  output tgtStrobe_t strb,
  output logic       sdaOe,
  output logic       busIdle
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] ALL_TX  = CNT_W'(BYTE_BITS);

  logic sclQ, sdaQ;
  logic sclRise, sclFall, startSeen, stopSeen;
  tgtState_t state, stateN;
  byteKind_t kind, kindN;
  logic dirRd, dirRdN;
  logic [CNT_W-1:0] bitCnt, bitCntN;

  assign sclRise   = sclS & ~sclQ;
  assign sclFall   = ~sclS & sclQ;
  assign startSeen = sclS & sclQ & sdaQ & ~sdaS;
  assign stopSeen  = sclS & sclQ & ~sdaQ & sdaS;

  always_comb begin
    strb    = '0;
    stateN  = state;
    kindN   = kind;
    dirRdN  = dirRd;
    bitCntN = bitCnt;
    if (startSeen) begin
      stateN  = ST_RX;
      kindN   = BY_ADDR;
      bitCntN = '0;
    end else if (stopSeen) begin
      stateN = ST_IDLE;
    end else begin
      case (state)
        ST_RX: if (sclRise) begin
          strb.shiftIn = 1'b1;
          bitCntN      = bitCnt + 1'b1;
          if (bitCnt == LAST_RX) begin
            bitCntN = '0;
            case (kind)
              BY_ADDR: begin
                if (rxLow7 == DEV_ADDR) begin
                  dirRdN = sdaS;
                  stateN = ST_ACK_WAIT;
                end else begin
                  stateN = ST_IDLE;
                end
              end
              BY_EXTRA: stateN = ST_IDLE;
              default:  stateN = ST_ACK_WAIT;
            endcase
          end
        end
        ST_ACK_WAIT: if (sclFall) stateN = ST_ACK_DRIVE;
        ST_ACK_DRIVE: if (sclRise) begin
          stateN        = ST_ACK_HOLD;
          strb.loadPtr  = (kind == BY_PTR);
          strb.commitWr = (kind == BY_DATA);
        end
        ST_ACK_HOLD: if (sclFall) begin
          bitCntN = '0;
          case (kind)
            BY_ADDR: begin
              if (dirRd) begin
                stateN      = ST_TX;
                strb.loadTx = 1'b1;
              end else begin
                stateN = ST_RX;
                kindN  = BY_PTR;
              end
            end
            BY_PTR:  begin stateN = ST_RX; kindN = BY_DATA;  end
            default: begin stateN = ST_RX; kindN = BY_EXTRA; end
          endcase
        end
        ST_TX: begin
          if (sclRise) bitCntN = bitCnt + 1'b1;
          if (sclFall) begin
            if (bitCnt == ALL_TX) stateN = ST_IDLE;
            else                  strb.shiftTx = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ   <= 1'b1;
      sdaQ   <= 1'b1;
      state  <= ST_IDLE;
      kind   <= BY_ADDR;
      dirRd  <= 1'b0;
      bitCnt <= '0;
    end else begin
      sclQ   <= sclS;
      sdaQ   <= sdaS;
      state  <= stateN;
      kind   <= kindN;
      dirRd  <= dirRdN;
      bitCnt <= bitCntN;
    end
  end

  assign sdaOe   = (state == ST_ACK_DRIVE) || (state == ST_ACK_HOLD) ||
                   ((state == ST_TX) && !txBit);
  assign busIdle = (state == ST_IDLE);
endmodule

// File: rtl/i2c_tgt_data.sv
module i2c_tgt_data
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int AW       = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  tgtStrobe_t    strb,
  input  logic          sdaS,
  input  logic [AW-1:0] hostAddr,
  input  logic          hostWe,
  input  logic [7:0]    hostWdata,
  output logic [7:0]    hostRdata,
  output logic [6:0]    rxLow7,
  output logic          txBit
);
  localparam logic [8:0] BANK_END = 9'(NUM_REGS);

  logic [7:0] rxByte, ptr, txShift, bankRd;
  logic [7:0] bank [NUM_REGS];
  logic       ptrHit;

  assign ptrHit = ({1'b0, ptr} < BANK_END);
  assign bankRd = ptrHit ? bank[ptr[AW-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      ptr     <= '0;
      txShift <= '0;
    end else begin
      if (strb.shiftIn) rxByte  <= {rxByte[6:0], sdaS};
      if (strb.loadPtr) ptr     <= rxByte;
      if (strb.loadTx)  txShift <= bankRd;
      else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bank[g] <= '0;
      end else if (strb.commitWr && ptrHit && (ptr == 8'(g))) begin
        bank[g] <= rxByte;
      end else if (hostWe && (hostAddr == AW'(g))) begin
        bank[g] <= hostWdata;
      end
    end
  end

  assign hostRdata = bank[hostAddr];
  assign rxLow7    = rxByte[6:0];
  assign txBit     = txShift[7];
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int          NUM_REGS = 8,
  parameter logic [6:0]  DEV_ADDR = 7'b0011010,
  parameter int          SYNC_STAGES = 2,
  localparam int         AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  output logic          sdaOe,
  input  logic [AW-1:0] hostAddr,
  input  logic          hostWe,
  input  logic [7:0]    hostWdata,
  output logic [7:0]    hostRdata
);
  logic       sclS, sdaS, txBit, busIdle;
  logic [6:0] rxLow7;
  tgtStrobe_t strb;

  i2c_tgt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rstN(rstN),
    .din ({sclIn, sdaIn}),
    .dout({sclS, sdaS})
  );

  i2c_tgt_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclS   (sclS),
    .sdaS   (sdaS),
    .rxLow7 (rxLow7),
    .txBit  (txBit),
    .strb   (strb),
    .sdaOe  (sdaOe),
    .busIdle(busIdle)
  );

  i2c_tgt_data #(.NUM_REGS(NUM_REGS), .AW(AW)) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .sdaS     (sdaS),
    .hostAddr (hostAddr),
    .hostWe   (hostWe),
    .hostWdata(hostWdata),
    .hostRdata(hostRdata),
    .rxLow7   (rxLow7),
    .txBit    (txBit)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          sclS,
  input logic          sdaS,
  input logic          sdaOe,
  input logic [AW-1:0] hostAddr,
  input logic          hostWe,
  input logic [7:0]    hostRdata,
  input logic          commitWr,
  input logic          busIdle
);
  // R1
  always_comb begin
    if (rstN === 1'b0) begin
      reset_release_chk: assert (!sdaOe);
    end
  end

  // R5
  oe_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);

  // R7
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> !sdaOe);

  // R4
  bank_change_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(hostWe) && $stable(hostAddr) && !$stable(hostRdata)) |-> $past(commitWr));

  // R8
  start_releases_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sdaS) && sclS && $past(sclS)) |=> !sdaOe);
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.AW(AW)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .sclS     (sclS),
  .sdaS     (sdaS),
  .sdaOe    (sdaOe),
  .hostAddr (hostAddr),
  .hostWe   (hostWe),
  .hostRdata(hostRdata),
  .commitWr (strb.commitWr),
  .busIdle  (busIdle)
);

// File: tb/i2c_reg_target_tb_top.sv
module i2c_reg_target_tb_top;
  localparam int NREG = 8;
  localparam int HALF = 8;
  localparam logic [6:0] DEV = 7'b0011010;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sdaOe;
  wire  sdaLine = mSda & ~sdaOe;
  logic [2:0] sweep = '0, wrAddr = '0;
  logic wrMode = 1'b0, hostWe = 1'b0;
  logic [7:0] hostWdata = '0, hostRdata;
  wire  [2:0] hostAddr = wrMode ? wrAddr : sweep;

  i2c_reg_target dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .hostAddr(hostAddr), .hostWe(hostWe), .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  int nVec = 0, nBad = 0, cyc = 0, riseCyc = 0;
  bit finished = 0;

  typedef struct { int when; int a; logic [7:0] d; } upd_t;
  upd_t pend[$];
  logic [7:0] model [NREG];
  logic armOn = 1'b0;
  int armA = 0;
  logic [7:0] armD = '0;

  function automatic void chk(logic [7:0] act, logic [7:0] exp, string req);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    sweep <= sweep + 1'b1;
  end

  // per-clock reference comparison of the bank (R4, R12, R1)
  always @(negedge clk) begin
    if (rstN) begin
      while (pend.size() > 0 && pend[0].when <= cyc) begin
        model[pend[0].a] = pend[0].d;
        void'(pend.pop_front());
      end
      chk(hostRdata, model[hostAddr], "R4 R12 bank compare");
    end
  end

  task automatic wt(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clk1(input logic b, output logic r);
    mScl = 1'b0; wt(2);
    mSda = b;    wt(HALF);
    mScl = 1'b1; riseCyc = cyc;
    if (armOn) begin
      pend.push_back('{riseCyc + 3, armA, armD});
      armOn = 1'b0;
    end
    wt(HALF / 2);
    r = sdaLine;
    wt(HALF / 2);
  endtask

  task automatic startC();
    mScl = 1'b0; wt(2);
    mSda = 1'b1; wt(HALF);
    mScl = 1'b1; wt(HALF);
    mSda = 1'b0; wt(HALF);
  endtask

  task automatic stopC();
    mScl = 1'b0; wt(2);
    mSda = 1'b0; wt(HALF);
    mScl = 1'b1; wt(HALF);
    mSda = 1'b1; wt(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic arm, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) clk1(b[i], r);
    armOn = arm;
    clk1(1'b1, r);
    acked = !r;
  endtask

  task automatic recvByte(output logic [7:0] v, output logic released);
    logic r;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      clk1(1'b1, r);
      v = {v[6:0], r};
    end
    clk1(1'b1, r);
    released = r;
  endtask

  task automatic i2cRead(input logic [7:0] ptr, output logic [7:0] v, output logic rel);
    logic a;
    startC();
    sendByte({DEV, 1'b0}, 1'b0, a); chk({7'b0, a}, 8'h01, "R2 address ack before read");
    sendByte(ptr, 1'b0, a);         chk({7'b0, a}, 8'h01, "R3 pointer ack before read");
    startC();
    sendByte({DEV, 1'b1}, 1'b0, a); chk({7'b0, a}, 8'h01, "R2 read address ack");
    recvByte(v, rel);
    stopC();
  endtask

  task automatic hostPoke(input logic [2:0] a, input logic [7:0] d);
    wrMode = 1'b1; wrAddr = a; hostWdata = d; hostWe = 1'b1;
    pend.push_back('{cyc + 1, int'(a), d});
    wt(1);
    hostWe = 1'b0; wrMode = 1'b0;
  endtask

  initial begin
    logic a;
    logic rel;
    logic [7:0] v;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    wt(4);
    rstN = 1'b1;
    wt(4);
    chk({7'b0, sdaOe}, 8'h00, "R1 sdaOe after reset");

    // plain write of 0xA5 to register 3
    startC();
    sendByte({DEV, 1'b0}, 1'b0, a); chk({7'b0, a}, 8'h01, "R2 address ack");
    sendByte(8'h03, 1'b0, a);       chk({7'b0, a}, 8'h01, "R3 pointer ack");
    armA = 3; armD = 8'hA5;
    sendByte(8'hA5, 1'b1, a);       chk({7'b0, a}, 8'h01, "R3 data ack");
    stopC();

    // combined read of register 3
    i2cRead(8'h03, v, rel);
    chk(v, 8'hA5, "R5 read data");
    chk({7'b0, rel}, 8'h01, "R6 released on controller ack bit");

    // mismatching address, write and read direction
    startC();
    sendByte({7'b0101011, 1'b0}, 1'b0, a); chk({7'b0, a}, 8'h00, "R7 no ack on mismatch");
    sendByte(8'h02, 1'b0, a);              chk({7'b0, a}, 8'h00, "R7 pointer ignored");
    sendByte(8'hFF, 1'b0, a);              chk({7'b0, a}, 8'h00, "R7 data ignored");
    stopC();
    startC();
    sendByte({7'b0011011, 1'b1}, 1'b0, a); chk({7'b0, a}, 8'h00, "R7 no ack read mismatch");
    stopC();

    // pointer outside the bank
    startC();
    sendByte({DEV, 1'b0}, 1'b0, a); chk({7'b0, a}, 8'h01, "R9 address ack");
    sendByte(8'h20, 1'b0, a);       chk({7'b0, a}, 8'h01, "R9 out-of-range pointer ack");
    sendByte(8'hFF, 1'b0, a);       chk({7'b0, a}, 8'h01, "R9 out-of-range data ack");
    stopC();
    i2cRead(8'h20, v, rel);
    chk(v, 8'h00, "R9 out-of-range read zero");
    i2cRead(8'h08, v, rel);
    chk(v, 8'h00, "R9 first index past bank reads zero");

    // parallel-port write then I2C readback
    hostPoke(3'd5, 8'h3C);
    wt(3);
    i2cRead(8'h05, v, rel);
    chk(v, 8'h3C, "R12 host write seen over I2C");

    // repeated START in the middle of a write
    startC();
    sendByte({DEV, 1'b0}, 1'b0, a); chk({7'b0, a}, 8'h01, "R8 first address ack");
    sendByte(8'h02, 1'b0, a);       chk({7'b0, a}, 8'h01, "R8 first pointer ack");
    startC();
    sendByte({DEV, 1'b0}, 1'b0, a); chk({7'b0, a}, 8'h01, "R8 address ack after restart");
    sendByte(8'h04, 1'b0, a);       chk({7'b0, a}, 8'h01, "R8 pointer ack after restart");
    armA = 4; armD = 8'h77;
    sendByte(8'h77, 1'b1, a);       chk({7'b0, a}, 8'h01, "R8 data ack after restart");
    stopC();

    // pointer kept across STOP
    startC();
    sendByte({DEV, 1'b0}, 1'b0, a);
    sendByte(8'h04, 1'b0, a);
    stopC();
    startC();
    sendByte({DEV, 1'b1}, 1'b0, a); chk({7'b0, a}, 8'h01, "R11 read address ack");
    recvByte(v, rel);
    stopC();
    chk(v, 8'h77, "R11 read uses kept pointer");

    // trailing second data byte
    startC();
    sendByte({DEV, 1'b0}, 1'b0, a);
    sendByte(8'h01, 1'b0, a);
    armA = 1; armD = 8'h11;
    sendByte(8'h11, 1'b1, a);       chk({7'b0, a}, 8'h01, "R10 first data ack");
    sendByte(8'h22, 1'b0, a);       chk({7'b0, a}, 8'h00, "R10 second data not acked");
    stopC();
    i2cRead(8'h01, v, rel);
    chk(v, 8'h11, "R10 second byte not stored");
    i2cRead(8'h02, v, rel);
    chk(v, 8'h00, "R8 register 2 untouched");

    wt(10);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nVec++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule